// File: doc/BRIEF.md
# Accumulator Stored-Program Core

This block is a small processor that runs programs held in one memory shared by code and data. Its working state is an accumulator plus five registers: program counter, address latch, read buffer, instruction holder and accumulator. A control sequencer moves each instruction through register-transfer microsteps. The address latch is loaded from the program counter. A read is issued. The returned word is parked in the read buffer and then moved into the instruction holder. The instruction is then decoded and carried out.

Each instruction is one 16-bit word. Bits [15:12] hold the operation and bits [11:0] hold a memory address. The core can load the accumulator, add to it, store it, and stop. It drives a single-port synchronous RAM that has a one-cycle read latency and sits outside the block. Once it stops, it raises a flag and stays frozen until reset.

Top module: `stored_prog_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator and sequencer. While reset is high, memRd, memWr and halted are low. After reset is released, the first instruction is read from address 0 with the accumulator at 0.
- R2: Every instruction begins with a five-cycle fetch: cycle 1 has no access, cycle 2 reads at the program counter, cycles 3 to 5 have no access. The word read is the instruction, with its operation in bits [15:12] and its address in bits [11:0].
- R3: The program counter advances by one after each fetch, so successive instructions are read from consecutive addresses (modulo 4096).
- R4: Operation 1 (load) reads the addressed word in cycle 6 of the instruction and places it in the accumulator. The instruction lasts 8 cycles.
- R5: Operation 3 (add) reads the addressed word in cycle 6 and adds it to the accumulator modulo 2^16. The instruction lasts 8 cycles.
- R6: Operation 2 (store) writes the accumulator to the addressed word in cycle 6. The instruction lasts 6 cycles.
- R7: Operation 7 (halt) raises halted in the cycle after decode. From then on, halted stays high and no memory access occurs until reset.
- R8: Every other operation code is a no-op. It lasts 5 cycles, makes no access beyond the fetch, and leaves the accumulator unchanged.
- R9: memRd and memWr are never high together. Read data is taken exactly one cycle after a read is issued, and that cycle makes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 12 | Memory word address (address latch contents) |
| memRd | output | 1 | Read request; data returns next cycle |
| memWr | output | 1 | Write request at memAddr |
| memWdata | output | 16 | Write data (accumulator) |
| memRdata | input | 16 | Read data from the RAM |
| halted | output | 1 | High once a halt has executed |

## Verification
The bench targets add overflow: 0xFFFF plus 2 must store 0x0001, so a carry kept or saturated would show up in memory. Undefined opcodes are placed between loads and stores. A core that decoded them as real operations would make extra accesses, or would shift the timing of later instructions against the model. A reset is applied while the accumulator holds a nonzero value, and the next program stores the accumulator at once; a design that left the accumulator uncleared would write stale data. After halt, the bench keeps clocking to catch any access or drop of the flag. Store data is read back by later loads, so a write that landed at the wrong cycle or the wrong address would corrupt those loads.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OP_STORE = 4'd2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OP_W-1:0] OP_HALT  = 4'd7;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic marFromPc;
    logic marFromIr;
    logic mbrLoad;
    logic irLoad;
    logic accLoad;
    logic accAdd;
  } strobe_t;
endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output strobe_t         strobe,
  output logic            memRd,
  output logic            memWr,
  output logic            halted
);
  typedef enum logic [3:0] {
    ST_MAR, ST_IREAD, ST_ILATCH, ST_IR, ST_DECODE,
    ST_OREAD, ST_OLATCH, ST_EXEC, ST_STORE, ST_HALT
  } state_t;

  state_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_MAR;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    memRd  = 1'b0;
    memWr  = 1'b0;
    halted = 1'b0;
    unique case (stateQ)
      ST_MAR: begin
        strobe.marFromPc = 1'b1;
        stateD = ST_IREAD;
      end
      ST_IREAD: begin
        memRd  = 1'b1;
        stateD = ST_ILATCH;
      end
      ST_ILATCH: begin
        strobe.mbrLoad = 1'b1;
        stateD = ST_IR;
      end
      ST_IR: begin
        strobe.irLoad = 1'b1;
        stateD = ST_DECODE;
      end
      ST_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_ADD) begin
          strobe.marFromIr = 1'b1;
          stateD = ST_OREAD;
        end else if (opcode == OP_STORE) begin
          strobe.marFromIr = 1'b1;
          stateD = ST_STORE;
        end else if (opcode == OP_HALT) begin
          stateD = ST_HALT;
        end else begin
          stateD = ST_MAR;
        end
      end
      ST_OREAD: begin
        memRd  = 1'b1;
        stateD = ST_OLATCH;
      end
      ST_OLATCH: begin
        strobe.mbrLoad = 1'b1;
        stateD = ST_EXEC;
      end
      ST_EXEC: begin
        strobe.accLoad = (opcode == OP_LOAD);
        strobe.accAdd  = (opcode == OP_ADD);
        stateD = ST_MAR;
      end
      ST_STORE: begin
        memWr  = 1'b1;
        stateD = ST_MAR;
      end
      ST_HALT: begin
        halted = 1'b1;
      end
      default: stateD = ST_MAR;
    endcase
  end
endmodule

// File: rtl/spc_dpath.sv
module spc_dpath
  import spc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [OP_W-1:0]   opcode
);
  localparam int OP_LSB = DATA_W - OP_W;

  logic [ADDR_W-1:0] pcQ, marQ;
  logic [DATA_W-1:0] mbrQ, irQ, accQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ  <= '0;
      marQ <= '0;
      mbrQ <= '0;
      irQ  <= '0;
      accQ <= '0;
    end else begin
      if (strobe.marFromPc) marQ <= pcQ;
      if (strobe.marFromIr) marQ <= irQ[ADDR_W-1:0];
      if (strobe.mbrLoad)   mbrQ <= memRdata;
      if (strobe.irLoad) begin
        irQ <= mbrQ;
        pcQ <= pcQ + 1'b1;
      end
      if (strobe.accLoad) accQ <= mbrQ;
      if (strobe.accAdd)  accQ <= accQ + mbrQ;
    end
  end

  assign memAddr  = marQ;
  assign memWdata = accQ;
  assign opcode   = irQ[DATA_W-1:OP_LSB];
endmodule

// File: rtl/stored_prog_core.sv
module stored_prog_core
  import spc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted
);
  strobe_t         strobe;
  logic [OP_W-1:0] opcode;

  spc_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .strobe (strobe),
    .memRd  (memRd),
    .memWr  (memWr),
    .halted (halted)
  );

  spc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker (
  input logic clk,
  input logic rst,
  input logic memRd,
  input logic memWr,
  input logic halted
);
  p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr));

  p_read_gap_r9: assert property (@(posedge clk) disable iff (rst)
    memRd |=> (!memRd && !memWr));

  p_write_gap_r6: assert property (@(posedge clk) disable iff (rst)
    memWr |=> (!memRd && !memWr && !halted));

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!memRd && !memWr));
endmodule

bind stored_prog_core spc_checker chk_i (
  .clk    (clk),
  .rst    (rst),
  .memRd  (memRd),
  .memWr  (memWr),
  .halted (halted)
);

// File: tb/stored_prog_core_tb_top.sv
`timescale 1ns/1ps
module stored_prog_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic        memRd, memWr, halted;
  logic [15:0] memWdata;
  logic [15:0] memRdata;

  logic        loadEn = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [15:0] loadData = '0;

  logic [15:0] mem [256];
  logic [15:0] img [256];
  logic [15:0] refMem [256];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int    expRd[$], expWr[$], expAddr[$], expData[$], expHalt[$];
  string expTag[$];

  always #4 clk = ~clk;

  stored_prog_core dut_i (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata), .halted(halted)
  );

  // synchronous RAM, one-cycle read latency
  always @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
    else if (memWr) mem[memAddr[7:0]] <= memWdata;
    if (memRd) memRdata <= mem[memAddr[7:0]];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog R2: run did not end, actual %0d cycles expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int rd, input int wr, input int a, input int d,
                      input int h, input string tag);
    expRd.push_back(rd); expWr.push_back(wr); expAddr.push_back(a);
    expData.push_back(d); expHalt.push_back(h); expTag.push_back(tag);
  endtask

  // behavioural reference: instruction-level interpreter emitting per-cycle bus events
  task automatic buildRef(input int n);
    int pc = 0;
    int acc = 0;
    int stop = 0;
    expRd.delete(); expWr.delete(); expAddr.delete();
    expData.delete(); expHalt.delete(); expTag.delete();
    for (int i = 0; i < 256; i++) refMem[i] = img[i];
    while (expRd.size() < n) begin
      if (stop) push(0, 0, 0, 0, 1, "R7");
      else begin
        int w = refMem[pc % 256];
        int op = (w >> 12) & 15;
        int a = w & 12'hfff;
        push(0, 0, 0, 0, 0, "R2");
        push(1, 0, pc, 0, 0, "R3");
        push(0, 0, 0, 0, 0, "R9");
        push(0, 0, 0, 0, 0, "R2");
        push(0, 0, 0, 0, 0, "R8");
        pc = (pc + 1) % 4096;
        case (op)
          1: begin
            push(1, 0, a, 0, 0, "R4"); push(0, 0, 0, 0, 0, "R9"); push(0, 0, 0, 0, 0, "R4");
            acc = refMem[a % 256];
          end
          3: begin
            push(1, 0, a, 0, 0, "R5"); push(0, 0, 0, 0, 0, "R9"); push(0, 0, 0, 0, 0, "R5");
            acc = (acc + refMem[a % 256]) & 16'hffff;
          end
          2: begin
            push(0, 1, a, acc, 0, "R6");
            refMem[a % 256] = acc[15:0];
          end
          7: stop = 1;
          default: ;
        endcase
      end
    end
  endtask

  task automatic loadImage();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = i[7:0]; loadData = img[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
    @(negedge clk);
    #1;
    check("R1 memRd in reset", memRd, 0);
    check("R1 memWr in reset", memWr, 0);
    check("R1 halted in reset", halted, 0);
  endtask

  task automatic runProg(input int n);
    buildRef(n);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < n; i++) begin
      int bad;
      #1;
      bad = 0;
      if (memRd !== expRd[i][0]) bad = 1;
      if (memWr !== expWr[i][0]) bad = 1;
      if (halted !== expHalt[i][0]) bad = 1;
      if ((memRd || memWr) && memAddr !== expAddr[i][11:0]) bad = 1;
      if (memWr && memWdata !== expData[i][15:0]) bad = 1;
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s cycle %0d: actual rd=%0b wr=%0b addr=0x%0h wd=0x%0h h=%0b expected rd=%0d wr=%0d addr=0x%0h wd=0x%0h h=%0d",
                 expTag[i], i, memRd, memWr, memAddr, memWdata, halted,
                 expRd[i], expWr[i], expAddr[i], expData[i], expHalt[i]);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    // program A: load, add, store, halt
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
    img[0] = 16'h1080; img[1] = 16'h3081; img[2] = 16'h2082; img[3] = 16'h7000;
    img[8'h80] = 16'h1234; img[8'h81] = 16'h0101; img[8'h82] = 16'hAAAA;
    loadImage();
    runProg(60);
    check("R6 stored sum", mem[8'h82], 16'h1335);
    check("R7 halted held", halted, 1);

    // program B: wrap-around add, undefined opcodes, store then reload
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
    img[0] = 16'h1090; img[1] = 16'h5123; img[2] = 16'h3091; img[3] = 16'h0000;
    img[4] = 16'h2092; img[5] = 16'hF0FF; img[6] = 16'h1092; img[7] = 16'h3092;
    img[8] = 16'h2093; img[9] = 16'h7000;
    img[8'h90] = 16'hFFFF; img[8'h91] = 16'h0002;
    img[8'hFF] = 16'h5555;
    loadImage();
    runProg(110);
    check("R5 wrap sum", mem[8'h92], 16'h0001);
    check("R8 nop leaves acc", mem[8'h93], 16'h0002);
    check("R8 nop wrote nothing", mem[8'hFF], 16'h5555);

    // program C: reset after a run leaves accumulator cleared
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
    img[0] = 16'h2095; img[1] = 16'h7000;
    img[8'h95] = 16'hBEEF;
    loadImage();
    runProg(30);
    check("R1 acc cleared by reset", mem[8'h95], 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule